// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a processor core that completes one instruction in every clock cycle. On each cycle it presents the program counter on an instruction-fetch port and takes back a 32-bit instruction word. It decodes that word in one of three layouts: register-register, immediate, or jump. It reads two operands from a 32-entry register file and computes a result. Before the next clock edge it commits the register write, the data-memory write and the next program counter.

The core supports register add, subtract and signed set-less-than. It also supports add-immediate, OR-immediate and load-upper-immediate, word load and store, equal and not-equal branches, absolute jump, jump-and-link and jump-through-register. Data memory is external. It is written on the clock edge and read combinationally through a word-address port. Any opcode or function code outside this set leaves all state unchanged except the program counter, which advances by 4.

Top module: `scr_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0, so `imem_addr` reads 0 while `rst` is high. It also clears every register to zero.
- R2: When not redirected, the program counter advances by 4 each cycle, and `imem_addr` always equals the program counter.
- R3: Register 0 always reads as zero, and a write that targets it is discarded.
- R4: A word with op field [31:26] = 0x00 is register-register. Its fields are rs = [25:21], rt = [20:16], rd = [15:11] and funct = [5:0]. Funct 0x20 writes rs+rt into rd. Funct 0x22 writes rs-rt into rd. Funct 0x2A writes 1 into rd when rs < rt as signed values, and 0 otherwise.
- R5: Immediate instructions use imm = [15:0] and write into rt. Op 0x08 writes rs + sign-extended imm. Op 0x0D writes rs OR zero-extended imm. Op 0x0F writes imm shifted left by 16, with the low half zero.
- R6: Load (op 0x23) and store (op 0x2B) use the byte address rs + sign-extended imm. `dmem_addr` carries that address with its two low bits dropped. Load writes `dmem_rdata` into rt. Store drives rt on `dmem_wdata` and raises `dmem_we`.
- R7: A load or store whose byte address has nonzero low two bits raises `dmem_err`. Memory is not written, and a misaligned load does not write its register.
- R8: Op 0x04 branches when rs equals rt, and op 0x05 branches when they differ. The target is PC+4 plus the sign-extended imm shifted left by 2. Otherwise the core continues at PC+4.
- R9: Op 0x02 jumps to {PC+4 bits [31:28], instruction bits [25:0], 2'b00}. Op 0x03 does the same and also writes PC+4 into register 31.
- R10: Op 0x00 with funct 0x08 loads the program counter from register rs.
- R11: Any other opcode, or any other funct under op 0x00, writes no register, does not write memory, and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 30 | Word address for the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the next rising clock edge |
| dmem_rdata | input | 32 | Combinational read data at `dmem_addr` |
| dmem_err | output | 1 | Misaligned load or store in the current cycle |

## Verification
One program runs from reset, and every register result is stored to data memory, where a table of expected words is compared against it. The arithmetic patterns pair a positive operand with a negative one in both orders. This separates signed from unsigned compare, add from subtract, and sign extension from zero extension. Branches are placed in taken and not-taken pairs, with poison instructions on the skipped paths, and the set of fetched addresses is recorded to show which paths ran. A jump-and-link/return pair, two undefined encodings aimed at live registers, and misaligned loads and stores aimed at cells that are already holding known values confirm the link value, the no-op behaviour and the write suppression.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int XLEN   = 32;
    localparam int REG_N  = 32;
    localparam int RIDX_W = $clog2(REG_N);
    localparam int IMM_W  = 16;

    // primary opcodes
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    // function codes under OP_RTYPE
    localparam logic [5:0] FN_JR  = 6'h08;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_LINK
    } wb_sel_e;

    typedef enum logic [1:0] {
        DST_RD, DST_RT, DST_LINK
    } dst_sel_e;

    typedef struct packed {
        logic     reg_we;
        wb_sel_e  wb;
        dst_sel_e dst;
        alu_op_e  alu;
        logic     b_imm;
        logic     imm_zext;
        logic     mem_rd;
        logic     mem_wr;
        logic     br;
        logic     br_ne;
        logic     jmp;
        logic     jreg;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/scr_decode.sv
module scr_decode
    import scr_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;  // unsupported encodings fall through as no-ops (R11)
        unique case (op)
            OP_RTYPE: begin
                unique case (funct)
                    FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RD; ctrl.alu = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RD; ctrl.alu = ALU_SUB; end
                    FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RD; ctrl.alu = ALU_SLT; end
                    FN_JR:  ctrl.jreg = 1'b1;
                    default: ;
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.alu = ALU_ADD; ctrl.b_imm = 1'b1;
            end
            OP_ORI: begin
                ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.alu = ALU_OR;
                ctrl.b_imm = 1'b1; ctrl.imm_zext = 1'b1;
            end
            OP_LUI: begin
                ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.alu = ALU_LUI;
                ctrl.b_imm = 1'b1; ctrl.imm_zext = 1'b1;
            end
            OP_LW: begin
                ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.wb = WB_MEM;
                ctrl.alu = ALU_ADD; ctrl.b_imm = 1'b1; ctrl.mem_rd = 1'b1;
            end
            OP_SW: begin
                ctrl.alu = ALU_ADD; ctrl.b_imm = 1'b1; ctrl.mem_wr = 1'b1;
            end
            OP_BEQ: ctrl.br = 1'b1;
            OP_BNE: begin ctrl.br = 1'b1; ctrl.br_ne = 1'b1; end
            OP_J:   ctrl.jmp = 1'b1;
            OP_JAL: begin
                ctrl.jmp = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = DST_LINK; ctrl.wb = WB_LINK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scr_alu.sv
module scr_alu
    import scr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int HALF = W / 2;

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_OR:  y = a | b;
            ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = '0;
        endcase
    end

    // R4
    always_comb begin
        if (op == ALU_SLT) begin
            slt_bool_chk: assert (y[W-1:1] == '0);
        end
    end

endmodule

// File: rtl/scr_regfile.sv
module scr_regfile #(
    parameter int N  = 32,
    parameter int W  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R4
    property p_write_readback;
        @(posedge clk) disable iff (rst)
        ($past(!rst) && $past(we) && $past(wa) != '0 && ra_a == $past(wa))
            |-> rd_a == $past(wd);
    endproperty
    wr_readback_chk: assert property (p_write_readback);

    // R3
    property p_zero_after_write;
        @(posedge clk) disable iff (rst)
        ($past(we) && $past(wa) == '0 && ra_b == '0) |-> rd_b == '0;
    endproperty
    zero_reg_chk: assert property (p_zero_after_write);

endmodule

// File: rtl/scr_core.sv
module scr_core
    import scr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-3:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_err
);

    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(REG_N - 1);
    localparam logic [XLEN-1:0]   STEP     = XLEN'(4);

    logic [XLEN-1:0]   pc, pc4, pc_nxt;
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic [IMM_W-1:0]  imm;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, wr_data;
    logic [XLEN-1:0]   br_tgt, j_tgt;
    logic              misalign, wr_en, take;

    assign rs_idx = imem_data[25:21];
    assign rt_idx = imem_data[20:16];
    assign rd_idx = imem_data[15:11];
    assign imm    = imem_data[IMM_W-1:0];

    scr_decode u_dec (
        .op    (imem_data[31:26]),
        .funct (imem_data[5:0]),
        .ctrl  (ctrl)
    );

    scr_regfile #(.N(REG_N), .W(XLEN)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (rs_idx),
        .ra_b (rt_idx),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (wr_en),
        .wa   (wr_idx),
        .wd   (wr_data)
    );

    assign imm_ext = ctrl.imm_zext ? zext_imm(imm) : sext_imm(imm);
    assign alu_b   = ctrl.b_imm ? imm_ext : rt_val;

    scr_alu #(.W(XLEN)) u_alu (
        .op (ctrl.alu),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    // memory side
    assign misalign   = (ctrl.mem_rd || ctrl.mem_wr) && (alu_y[1:0] != 2'b00);
    assign dmem_err   = misalign;
    assign dmem_addr  = alu_y[XLEN-1:2];
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr && !misalign;

    // write-back
    always_comb begin
        unique case (ctrl.dst)
            DST_RT:   wr_idx = rt_idx;
            DST_LINK: wr_idx = LINK_REG;
            default:  wr_idx = rd_idx;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  wr_data = dmem_rdata;
            WB_LINK: wr_data = pc4;
            default: wr_data = alu_y;
        endcase
    end
    assign wr_en = ctrl.reg_we && !(ctrl.mem_rd && misalign);

    // next program counter
    assign pc4    = pc + STEP;
    assign br_tgt = pc4 + {sext_imm(imm)[XLEN-3:0], 2'b00};
    assign j_tgt  = {pc4[XLEN-1:XLEN-4], imem_data[25:0], 2'b00};
    assign take   = ctrl.br && ((rs_val == rt_val) ^ ctrl.br_ne);

    always_comb begin
        if (ctrl.jreg)     pc_nxt = rs_val;
        else if (ctrl.jmp) pc_nxt = j_tgt;
        else if (take)     pc_nxt = br_tgt;
        else               pc_nxt = pc4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_nxt;
    end

    assign imem_addr = pc;

    // R1
    property p_reset_pc;
        @(posedge clk) disable iff (rst)
        $past(rst) |-> imem_addr == '0;
    endproperty
    reset_pc_chk: assert property (p_reset_pc);

    // R2
    property p_seq_pc;
        @(posedge clk) disable iff (rst)
        (!ctrl.br && !ctrl.jmp && !ctrl.jreg) |=> imem_addr == $past(imem_addr) + STEP;
    endproperty
    seq_pc_chk: assert property (p_seq_pc);

    // R7
    property p_misalign_no_store;
        @(posedge clk) disable iff (rst)
        (ctrl.mem_wr && alu_y[1:0] != 2'b00) |-> (!dmem_we && dmem_err);
    endproperty
    misalign_store_chk: assert property (p_misalign_no_store);

    // R9
    property p_link_value;
        @(posedge clk) disable iff (rst)
        (ctrl.jmp && wr_en) |-> (wr_idx == LINK_REG && wr_data == imem_addr + STEP);
    endproperty
    link_value_chk: assert property (p_link_value);

endmodule

// File: tb/scr_core_bench.sv
`timescale 1ns/1ps
module scr_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_wdata, dmem_rdata;
    logic [29:0] dmem_addr;
    logic        dmem_we, dmem_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    scr_core u_scr_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .dmem_err(dmem_err)
    );

    // ---------------- memories ----------------
    logic [31:0] prog [64];
    logic [31:0] dmem [64];

    assign imem_data  = prog[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) dmem[i] <= 32'hDEAD_BEEF;
        end else if (dmem_we) begin
            dmem[dmem_addr[5:0]] <= dmem_wdata;
        end
    end

    // ---------------- encoders ----------------
    function automatic logic [31:0] e_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] e_i(input logic [5:0] op, input int rs, rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_j(input logic [5:0] op, input int word_tgt);
        return {op, 26'(word_tgt)};
    endfunction

    // ---------------- monitor ----------------
    logic [63:0] seen = '0;
    int err_cnt = 0;
    int err_we  = 0;
    logic seen_err_at_160 = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            seen[imem_addr[7:2]] = 1'b1;
            if (dmem_err) begin
                err_cnt++;
                if (imem_addr == 32'd160) seen_err_at_160 = 1'b1;
                if (dmem_we) err_we++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected data-memory words, index = word address
    localparam logic [31:0] EXP_MEM [16] = '{
        32'h0000_0005,  // R5 addi +5, R7 misaligned sw left it
        32'hFFFF_FFFD,  // R5 addi -3 sign-extended
        32'h0000_0002,  // R4 add
        32'hFFFF_FFF8,  // R4 sub
        32'h0000_0001,  // R4 slt signed true
        32'h0000_0000,  // R4 slt signed false
        32'h1234_ABCD,  // R5 lui + ori
        32'h0000_0000,  // R3 write to r0 discarded
        32'h1234_ABCD,  // R6 lw then sw with negative offset
        32'h0000_0003,  // R8 branch pairs
        32'h0000_0074,  // R9 link value
        32'h0000_0077,  // R10 subroutine ran, return reached
        32'h0000_0077,  // R11 undefined op left r11
        32'h0000_0074,  // R11 undefined op left r31
        32'h0000_0005,  // R11 undefined funct left r1
        32'h0000_0000   // R7 misaligned lw did not write r12
    };
    localparam int EXP_REQ [16] = '{5,5,4,4,4,4,5,3,6,8,9,10,11,11,11,7};

    localparam logic [5:0] ADDI = 6'h08, ORI = 6'h0D, LUI = 6'h0F, LW = 6'h23,
                           SW = 6'h2B, BEQ = 6'h04, BNE = 6'h05, J = 6'h02, JAL = 6'h03;

    task automatic load_program();
        for (int i = 0; i < 64; i++) prog[i] = 32'h0000_0000;
        prog[0]  = e_i(ADDI, 0, 1, 5);
        prog[1]  = e_i(ADDI, 0, 2, -3);
        prog[2]  = e_r(1, 2, 3, 6'h20);
        prog[3]  = e_r(2, 1, 4, 6'h22);
        prog[4]  = e_r(2, 1, 5, 6'h2A);
        prog[5]  = e_r(1, 2, 6, 6'h2A);
        prog[6]  = e_i(LUI, 0, 7, 16'h1234);
        prog[7]  = e_i(ORI, 7, 7, 16'hABCD);
        prog[8]  = e_i(ADDI, 0, 0, 7);
        prog[9]  = e_i(SW, 0, 1, 0);
        prog[10] = e_i(SW, 0, 2, 4);
        prog[11] = e_i(SW, 0, 3, 8);
        prog[12] = e_i(SW, 0, 4, 12);
        prog[13] = e_i(SW, 0, 5, 16);
        prog[14] = e_i(SW, 0, 6, 20);
        prog[15] = e_i(SW, 0, 7, 24);
        prog[16] = e_i(SW, 0, 0, 28);
        prog[17] = e_i(LW, 0, 8, 24);
        prog[18] = e_i(ADDI, 0, 9, 36);
        prog[19] = e_i(SW, 9, 8, -4);
        prog[20] = e_i(BEQ, 1, 2, 1);
        prog[21] = e_i(ADDI, 0, 10, 1);
        prog[22] = e_i(BEQ, 1, 1, 1);
        prog[23] = e_i(ADDI, 10, 10, 100);
        prog[24] = e_i(BNE, 1, 1, 1);
        prog[25] = e_i(ADDI, 10, 10, 2);
        prog[26] = e_i(BNE, 1, 2, 1);
        prog[27] = e_i(ADDI, 10, 10, 100);
        prog[28] = e_j(JAL, 32);
        prog[29] = e_i(SW, 0, 10, 36);
        prog[30] = e_i(SW, 0, 31, 40);
        prog[31] = e_j(J, 35);
        prog[32] = e_i(ADDI, 0, 11, 16'h77);
        prog[33] = e_i(SW, 0, 11, 44);
        prog[34] = e_r(31, 0, 0, 6'h08);
        prog[35] = 32'hFFFF_FFFF;          // undefined op, rt/rs fields = 31
        prog[36] = e_i(SW, 0, 11, 48);
        prog[37] = e_i(SW, 0, 31, 52);
        prog[38] = e_r(1, 1, 1, 6'h3F);    // undefined funct aimed at r1
        prog[39] = e_i(SW, 0, 1, 56);
        prog[40] = e_i(SW, 0, 1, 2);       // misaligned store onto word 0
        prog[41] = e_i(LW, 0, 12, 1);      // misaligned load into r12
        prog[42] = e_i(SW, 0, 12, 60);
        prog[43] = e_j(J, 43);             // halt loop
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        load_program();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", imem_addr, 32'd0, "pc held in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R2", imem_addr, 32'd4, "first step after reset");
        repeat (80) @(negedge clk);

        for (int i = 0; i < 16; i++)
            check($sformatf("R%0d", EXP_REQ[i]), dmem[i], EXP_MEM[i], $sformatf("dmem word %0d", i));

        check("R8",  {31'd0, seen[23]}, 32'd0, "taken beq skipped word 23");
        check("R8",  {31'd0, seen[27]}, 32'd0, "taken bne skipped word 27");
        check("R8",  {31'd0, seen[21]}, 32'd1, "not-taken beq fell through");
        check("R9",  {31'd0, seen[32]}, 32'd1, "jal target fetched");
        check("R10", {31'd0, seen[29]}, 32'd1, "jr returned to link");
        check("R9",  imem_addr, 32'd172, "j self-loop holds pc");
        check("R7",  32'(err_cnt), 32'd2, "misaligned access count");
        check("R7",  {31'd0, seen_err_at_160}, 32'd1, "err on misaligned store");
        check("R7",  32'(err_we), 32'd0, "no strobe with err");
        check("R6",  {31'd0, dmem_we}, 32'd0, "no strobe in halt loop");

        // mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check("R1", imem_addr, 32'd0, "pc cleared by mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2", imem_addr, 32'd4, "restart sequencing");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule